// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

The block takes one fast input clock and produces two banks of divided clocks. Bank A divides the input by 2 or by 4. Bank B divides it by 4, 5 or 6. Each bank drives two identical outputs. The odd ratio has a 50% duty cycle: its output goes high on a rising input edge and goes low on a falling input edge.

An active-low enable may change at any time relative to the clock. It passes through a two-stage synchronizer on the falling clock edge. Each bank samples the synchronized enable only at the end of an output period. Stopping therefore never cuts a pulse short, and starting always begins a fresh full-width period. A select change is also taken only at a period boundary. An active-high asynchronous reset clears all state and drives every output low.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: While `rstIn` is high all four outputs are low, and raising `rstIn` while the outputs run forces them low at once, without waiting for a clock edge.
- R2: When `enN` is held low and `rstIn` is released just after a rising clock edge, all running outputs first go high on the second rising edge after the release.
- R3: Bank A divides by 2 when `selA`=0 and by 4 when `selA`=1. The output is high for N/2 input cycles and low for N/2 input cycles.
- R4: Bank B divides by 4 when `selB`=00 and by 6 when `selB`=01. It divides by 5 when `selB`=10 and also when `selB`=11.
- R5: `qA0` always equals `qA1`, and `qB0` always equals `qB1`.
- R6: At divide-by-5 the output is high for 2.5 input cycles and low for 2.5 input cycles. It rises on a rising input edge and falls on a falling input edge.
- R7: After `enN` goes high, each bank finishes its current period in full. The bank then holds its outputs low for as long as `enN` stays high.
- R8: After `enN` goes low again, each bank starts a new period. The first high pulse has full width, and no low gap is shorter than a half period.
- R9: A change of `selA` or `selB` takes effect only at the end of the bank's current period. Every period has equal high and low times at the old ratio or at the new ratio, never a mix of the two.
- R10: Out of reset, banks set to the same ratio (`selA`=1 and `selB`=00) produce identical waveforms edge for edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Fast input clock |
| rstIn | input | 1 | Asynchronous reset, active high |
| enN | input | 1 | Output enable, active low, asynchronous |
| selA | input | 1 | Bank A ratio select |
| selB | input | 2 | Bank B ratio select |
| qA0 | output | 1 | Bank A divided clock, copy 0 |
| qA1 | output | 1 | Bank A divided clock, copy 1 |
| qB0 | output | 1 | Bank B divided clock, copy 0 |
| qB1 | output | 1 | Bank B divided clock, copy 1 |

## Verification
Enable latency is fixed: a change on `enN` reaches a bank after two falling edges, and the bank acts on it at its next rising edge. The bench checks the start of output at exactly the second rising edge after reset release and samples a quarter period after each edge. Even-ratio outputs change just after a rising edge. The divide-by-5 output also changes just after a falling edge. For that reason the bench samples both half-cycles and judges each waveform by the length of its complete high and low runs in half-cycles, never by the phase of a single cycle. Enable and select changes are placed mid-period, and the run lengths show that no period was cut short.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  parameter int unsigned RATIO_W = 3;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic   runEn;
    ratio_t ratioA;
    ratio_t ratioB;
  } ctrlStrobes_t;

  function automatic ratio_t decodeA(input logic sel);
    return sel ? ratio_t'(4) : ratio_t'(2);
  endfunction

  function automatic ratio_t decodeB(input logic [1:0] sel);
    ratio_t r;
    case (sel)
      2'b00:   r = ratio_t'(4);
      2'b01:   r = ratio_t'(6);
      default: r = ratio_t'(5);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enN,
  input  logic         selA,
  input  logic [1:0]   selB,
  output ctrlStrobes_t strobes
);
  logic [SYNC_STAGES-1:0] syncChain;

  always_ff @(negedge clk or posedge rst) begin
    if (rst) syncChain <= '0;
    else     syncChain <= {syncChain[SYNC_STAGES-2:0], ~enN};
  end

  always_comb begin
    strobes.runEn  = syncChain[SYNC_STAGES-1];
    strobes.ratioA = decodeA(selA);
    strobes.ratioB = decodeB(selB);
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter bit HAS_ODD = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   runEn,
  input  ratio_t ratioSel,
  output logic   divOut
);
  ratio_t cnt, ratioLat, nCnt, nRatio;
  logic   running, nRun, hiPos, nHi, wrap;

  always_comb begin
    wrap   = running && (cnt == ratioLat - ratio_t'(1));
    nCnt   = cnt;
    nRatio = ratioLat;
    nRun   = running;
    if (!running) begin
      nCnt = '0;
      if (runEn) begin
        nRun   = 1'b1;
        nRatio = ratioSel;
      end
    end else if (wrap) begin
      nCnt = '0;
      if (runEn) nRatio = ratioSel;
      else       nRun   = 1'b0;
    end else begin
      nCnt = cnt + ratio_t'(1);
    end
    nHi = nRun && (nCnt < (nRatio >> 1));
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt      <= '0;
      ratioLat <= '0;
      running  <= 1'b0;
      hiPos    <= 1'b0;
    end else begin
      cnt      <= nCnt;
      ratioLat <= nRatio;
      running  <= nRun;
      hiPos    <= nHi;
    end
  end

  generate
    if (HAS_ODD) begin : g_odd
      logic hiNeg;
      always_ff @(negedge clk or posedge rst) begin
        if (rst) hiNeg <= 1'b0;
        else     hiNeg <= hiPos & ratioLat[0];
      end
      assign divOut = hiPos | hiNeg;
    end else begin : g_even
      assign divOut = hiPos;
    end
  endgenerate

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < ratioLat)); // R3
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !running |-> !hiPos); // R7
  AST_RATIO_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (running && cnt != '0) |-> $stable(ratioLat)); // R9
  AST_START_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> (cnt == '0 && hiPos)); // R8
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  output logic         divA,
  output logic         divB
);
  clkdiv_bank #(.HAS_ODD(1'b0)) u_bankA (
    .clk(clk), .rst(rst), .runEn(strobes.runEn),
    .ratioSel(strobes.ratioA), .divOut(divA)
  );
  clkdiv_bank #(.HAS_ODD(1'b1)) u_bankB (
    .clk(clk), .rst(rst), .runEn(strobes.runEn),
    .ratioSel(strobes.ratioB), .divOut(divB)
  );
endmodule

// File: rtl/dual_bank_clkdiv.sv
module dual_bank_clkdiv
  import clkdiv_pkg::*;
(
  input  logic       clkIn,
  input  logic       rstIn,
  input  logic       enN,
  input  logic       selA,
  input  logic [1:0] selB,
  output logic       qA0,
  output logic       qA1,
  output logic       qB0,
  output logic       qB1
);
  ctrlStrobes_t strobes;
  logic divA, divB;

  clkdiv_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clkIn), .rst(rstIn), .enN(enN),
    .selA(selA), .selB(selB), .strobes(strobes)
  );
  clkdiv_datapath u_dp (
    .clk(clkIn), .rst(rstIn), .strobes(strobes),
    .divA(divA), .divB(divB)
  );

  assign qA0 = divA;
  assign qA1 = divA;
  assign qB0 = divB;
  assign qB1 = divB;
endmodule

// File: tb/sim_dual_bank_clkdiv.sv
module sim_dual_bank_clkdiv;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 400;

  logic clk = 1'b0, rst = 1'b1, enN = 1'b0, selA = 1'b1;
  logic [1:0] selB = 2'b00;
  logic qA0, qA1, qB0, qB1;
  int checks = 0, errors = 0, pairErr = 0, alignErr = 0;
  bit sa [MAXS];
  bit sb [MAXS];
  int runVal [MAXS];
  int runLen [MAXS];
  int nRuns;

  dual_bank_clkdiv u0 (.clkIn(clk), .rstIn(rst), .enN(enN), .selA(selA),
    .selB(selB), .qA0(qA0), .qA1(qA1), .qB0(qB0), .qB1(qB1));

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic capture(input int n);
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 1) @(negedge clk);
      else if (i != 0) @(posedge clk);
      #(CLK_PERIOD/4);
      sa[i] = qA0; sb[i] = qB0;
      if (qA0 !== qA1 || qB0 !== qB1) pairErr++;
      if (qA0 !== qB0) alignErr++;
    end
  endtask

  task automatic collectRuns(input bit useB, input int n);
    bit cur, v, first;
    int len;
    nRuns = 0; first = 1'b1; len = 1;
    cur = useB ? sb[0] : sa[0];
    for (int i = 1; i < n; i++) begin
      v = useB ? sb[i] : sa[i];
      if (v == cur) len++;
      else begin
        if (!first) begin
          runVal[nRuns] = cur; runLen[nRuns] = len; nRuns++;
        end
        first = 1'b0; cur = v; len = 1;
      end
    end
  endtask

  task automatic checkSteady(input bit useB, input int ratio, input string tag);
    int bad = ratio;
    repeat (14) @(posedge clk);
    capture(160);
    collectRuns(useB, 160);
    for (int i = 0; i < nRuns; i++) if (runLen[i] != ratio) bad = runLen[i];
    chk(nRuns >= 4 && bad == ratio, tag, bad, ratio);
  endtask

  task automatic testReset();
    #(CLK_PERIOD/4);
    chk({qA0, qA1, qB0, qB1} == 4'b0, "R1 outputs low in reset", {qA0, qA1, qB0, qB1}, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(posedge clk); #(CLK_PERIOD/4);
    chk(qA0 == 1'b0, "R2 low at first edge after release", qA0, 0);
    @(posedge clk); #(CLK_PERIOD/4);
    chk(qA0 == 1'b1 && qB0 == 1'b1, "R2 high at second edge after release", {qA0, qB0}, 3);
    alignErr = 0;
    capture(200);
    chk(alignErr == 0, "R10 equal-ratio banks aligned", alignErr, 0);
  endtask

  task automatic testBankA();
    selA = 1'b0;
    checkSteady(1'b0, 2, "R3 bank A sel=0 divide by 2");
    selA = 1'b1;
    checkSteady(1'b0, 4, "R3 bank A sel=1 divide by 4");
  endtask

  task automatic testBankB();
    selB = 2'b00; checkSteady(1'b1, 4, "R4 bank B sel=00 divide by 4");
    selB = 2'b01; checkSteady(1'b1, 6, "R4 bank B sel=01 divide by 6");
    selB = 2'b10; checkSteady(1'b1, 5, "R6 bank B sel=10 divide by 5 half-cycle runs");
    selB = 2'b11; checkSteady(1'b1, 5, "R4 bank B sel=11 divide by 5");
  endtask

  task automatic testSelChange();
    int bad = 0, n4 = 0, n6 = 0;
    selB = 2'b00;
    repeat (14) @(posedge clk);
    fork
      capture(300);
      begin #(13*CLK_PERIOD + 3); selB = 2'b01; end
    join
    collectRuns(1'b1, 300);
    for (int i = 0; i + 1 < nRuns; i += 2) begin
      if (runLen[i] != runLen[i+1]) bad++;
      if (runLen[i] == 4) n4++;
      else if (runLen[i] == 6) n6++;
      else bad++;
    end
    chk(bad == 0 && n4 > 0 && n6 > 0, "R9 select change at period end", bad, 0);
  endtask

  task automatic testDisable();
    int bad = 0, nz = 0;
    selB = 2'b10;
    repeat (14) @(posedge clk);
    fork
      capture(300);
      begin #(11*CLK_PERIOD + 2); enN = 1'b1; end
    join
    collectRuns(1'b1, 300);
    for (int i = 0; i < nRuns; i++) if (runVal[i] == 1 && runLen[i] != 5) bad++;
    for (int i = 200; i < 300; i++) if (sa[i] || sb[i]) nz++;
    chk(bad == 0, "R7 no truncated pulse on disable", bad, 0);
    chk(nz == 0, "R7 outputs held low while disabled", nz, 0);
    fork
      capture(300);
      begin #(27*CLK_PERIOD + 7); enN = 1'b0; end
    join
    collectRuns(1'b1, 300);
    bad = 0;
    for (int i = 0; i < nRuns; i++) begin
      if (runVal[i] == 1 && runLen[i] != 5) bad++;
      if (runVal[i] == 0 && runLen[i] < 5) bad++;
    end
    chk(bad == 0 && nRuns >= 4, "R8 full pulses after re-enable", bad, 0);
  endtask

  task automatic testPairs();
    chk(pairErr == 0, "R5 duplicate outputs match", pairErr, 0);
  endtask

  task automatic testAsyncReset();
    selA = 1'b1;
    @(posedge clk);
    while (qA0 !== 1'b1) @(posedge clk);
    #(CLK_PERIOD/4) rst = 1'b1;
    #1;
    chk({qA0, qA1, qB0, qB1} == 4'b0, "R1 asynchronous reset clears outputs", {qA0, qA1, qB0, qB1}, 0);
    @(posedge clk); #1 rst = 1'b0;
  endtask

  initial begin
    #(100000*CLK_PERIOD);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testBankA();
    testBankB();
    testSelChange();
    testDisable();
    testAsyncReset();
    testPairs();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule